// File: doc/BRIEF.md
# Paged Segment Address Translator

This block turns a 32-bit virtual address into a physical address by walking two levels of tables held in ordinary memory. The virtual address splits into a segment index (top 4 bits), a page index (middle 16 bits) and a byte offset (low 12 bits). The segment index selects a descriptor in a segment table whose base address sits in a register that software loads. That descriptor names the page table for the segment and gives its length in pages. The page index then selects a page descriptor, which supplies the frame number.

Requests arrive on a valid/ready handshake, one at a time. The block issues its table reads on a valid/ready read port whose response may come any number of cycles later. It returns one result per request on a second valid/ready handshake. Each result carries a physical address and a two-bit status. There are three failure kinds, checked in this order: a segment descriptor marked not valid (segment exception), a page index at or past the segment length (bounds exception), and a page descriptor marked not valid (page fault). The first two skip the page table read.

Top module: `seg_xlate`

## Requirements
- R1: During and after synchronous reset, `req_ready` is 1 and `rsp_valid` and `mem_req_valid` are 0, until a request is accepted.
- R2: The first read of each walk goes to `tbl_base + 4*segment`, where `tbl_base` is the last value written through `cfg_we`/`cfg_base` before the request was accepted.
- R3: The second read goes to `{seg_desc[31:12], 12'h000} + 4*page`. A segment descriptor holds the page table base in bits 31:12, the length in pages in bits 11:1 and valid in bit 0.
- R4: A segment descriptor with bit 0 clear gives status 1 (segment exception), `rsp_paddr` 0 and no page table read.
- R5: A page index greater than or equal to the segment length gives status 2 (bounds exception), `rsp_paddr` 0 and no page table read. A length of 0 faults every page, and the last page below the length translates.
- R6: A page descriptor with bit 0 clear gives status 3 (page fault) and `rsp_paddr` 0.
- R7: A valid page descriptor gives status 0 and `rsp_paddr = {page_desc[31:12], offset}`.
- R8: Once `mem_req_valid` is raised, it and `mem_req_addr` stay unchanged until `mem_req_ready` is seen. Reads tolerate any response latency of one cycle or more.
- R9: Once `rsp_valid` is raised, the result stays unchanged until `rsp_ready` is seen. `req_ready` stays 0 from acceptance until the result is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Load the segment table base register |
| cfg_base | input | 32 | New segment table base address |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | 32 | Virtual address: segment, page, offset |
| rsp_valid | output | 1 | Result present |
| rsp_ready | input | 1 | Consumer takes the result |
| rsp_paddr | output | 32 | Physical address, 0 on any fault |
| rsp_status | output | 2 | 0 ok, 1 segment exception, 2 bounds, 3 page fault |
| mem_req_valid | output | 1 | Table read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Byte address of the descriptor |
| mem_rsp_valid | input | 1 | Read data present for one cycle |
| mem_rsp_data | input | 32 | Descriptor read from memory |

## Verification
The bench aims at the edges of the length check. It uses the last page inside a segment, the first page past it, a zero-length segment, and a page index wider than the length field. An off-by-one comparison or a truncated compare would let an out-of-range page through or reject a legal one. Every memory address is matched in order against an expected list, so a design that reads the page table after a segment or bounds fault, or that scales or offsets an index wrongly, shows up as an extra or mismatched read. Memory ready stalls, response latencies of 1 to 4 cycles and a consumer that stalls the result expose a design that drops a held request or changes its result while it waits. A mid-run change of the table base catches a design that latched the base too early or ignored it.

// File: rtl/seg_xlate_pkg.sv
package seg_xlate_pkg;

  typedef enum logic [1:0] {
    XL_OK        = 2'd0,
    XL_SEG_EXC   = 2'd1,
    XL_BOUNDS    = 2'd2,
    XL_PAGE_FLT  = 2'd3
  } xl_status_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_SEG_RD,
    S_PAGE_RD,
    S_RESP
  } xl_state_e;

endpackage

// File: rtl/seg_xlate_addr.sv
module seg_xlate_addr #(
  parameter int ADDR_W      = 32,
  parameter int SEG_W       = 4,
  parameter int PAGE_W      = 16,
  parameter int OFF_W       = 12,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic [ADDR_W-1:0]       tbl_base,
  input  logic [SEG_W-1:0]        seg_idx,
  input  logic [PAGE_W-1:0]       page_idx,
  input  logic [ADDR_W-OFF_W-1:0] pt_frame,
  output logic [ADDR_W-1:0]       seg_ent_addr,
  output logic [ADDR_W-1:0]       pte_addr
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [ADDR_W-1:0] seg_scaled;
  logic [ADDR_W-1:0] page_scaled;
  logic [ADDR_W-1:0] pt_base;

  always_comb begin
    seg_scaled   = ADDR_W'(seg_idx) << ENTRY_SHIFT;
    page_scaled  = ADDR_W'(page_idx) << ENTRY_SHIFT;
    pt_base      = {pt_frame[FRAME_W-1:0], {OFF_W{1'b0}}};
    seg_ent_addr = tbl_base + seg_scaled;
    pte_addr     = pt_base + page_scaled;
  end
endmodule

// File: rtl/seg_xlate_decode.sv
module seg_xlate_decode #(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 16,
  parameter int OFF_W  = 12,
  parameter int LEN_W  = 11
) (
  input  logic [ADDR_W-1:0]       desc,
  input  logic [PAGE_W-1:0]       page_idx,
  input  logic [OFF_W-1:0]        offset,
  output logic                    desc_valid,
  output logic                    in_bounds,
  output logic [ADDR_W-OFF_W-1:0] frame,
  output logic [ADDR_W-1:0]       paddr
);
  localparam int CMP_W = (PAGE_W > LEN_W) ? PAGE_W : LEN_W;

  logic [LEN_W-1:0] seg_len;

  always_comb begin
    desc_valid = desc[0];
    seg_len    = desc[LEN_W:1];
    frame      = desc[ADDR_W-1:OFF_W];
    in_bounds  = CMP_W'(page_idx) < CMP_W'(seg_len);
    paddr      = {frame, offset};
  end
endmodule

// File: rtl/seg_xlate.sv
module seg_xlate
  import seg_xlate_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SEG_W       = 4,
  parameter int PAGE_W      = 16,
  parameter int OFF_W       = 12,
  parameter int LEN_W       = 11,
  parameter int ENTRY_SHIFT = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [ADDR_W-1:0] cfg_base,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_vaddr,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [ADDR_W-1:0] rsp_paddr,
  output logic [1:0]        rsp_status,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [ADDR_W-1:0] mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [ADDR_W-1:0] mem_rsp_data
);
  localparam int PAGE_LSB = OFF_W;
  localparam int SEG_LSB  = OFF_W + PAGE_W;
  localparam int FRAME_W  = ADDR_W - OFF_W;

  xl_state_e         state;
  logic              issued;
  logic [ADDR_W-1:0] tbl_base_q;
  logic [ADDR_W-1:0] vaddr_q;

  logic [ADDR_W-1:0]  seg_ent_addr;
  logic [ADDR_W-1:0]  pte_addr;
  logic               desc_valid;
  logic               in_bounds;
  logic [FRAME_W-1:0] frame;
  logic [ADDR_W-1:0]  hit_paddr;
  logic               rd_done;

  seg_xlate_addr #(
    .ADDR_W(ADDR_W), .SEG_W(SEG_W), .PAGE_W(PAGE_W),
    .OFF_W(OFF_W), .ENTRY_SHIFT(ENTRY_SHIFT)
  ) u_addr (
    .tbl_base     (tbl_base_q),
    .seg_idx      (req_vaddr[SEG_LSB +: SEG_W]),
    .page_idx     (vaddr_q[PAGE_LSB +: PAGE_W]),
    .pt_frame     (frame),
    .seg_ent_addr (seg_ent_addr),
    .pte_addr     (pte_addr)
  );

  seg_xlate_decode #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .OFF_W(OFF_W), .LEN_W(LEN_W)
  ) u_dec (
    .desc       (mem_rsp_data),
    .page_idx   (vaddr_q[PAGE_LSB +: PAGE_W]),
    .offset     (vaddr_q[OFF_W-1:0]),
    .desc_valid (desc_valid),
    .in_bounds  (in_bounds),
    .frame      (frame),
    .paddr      (hit_paddr)
  );

  assign req_ready = (state == S_IDLE);
  assign rd_done   = issued && mem_rsp_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= S_IDLE;
      issued        <= 1'b0;
      tbl_base_q    <= '0;
      vaddr_q       <= '0;
      mem_req_valid <= 1'b0;
      mem_req_addr  <= '0;
      rsp_valid     <= 1'b0;
      rsp_paddr     <= '0;
      rsp_status    <= XL_OK;
    end else begin
      if (cfg_we) tbl_base_q <= cfg_base;

      if (mem_req_valid && mem_req_ready) begin
        mem_req_valid <= 1'b0;
        issued        <= 1'b1;
      end

      case (state)
        S_IDLE: begin
          if (req_valid) begin
            vaddr_q       <= req_vaddr;
            mem_req_valid <= 1'b1;
            mem_req_addr  <= seg_ent_addr;
            issued        <= 1'b0;
            state         <= S_SEG_RD;
          end
        end
        S_SEG_RD: begin
          if (rd_done) begin
            if (!desc_valid || !in_bounds) begin
              rsp_valid  <= 1'b1;
              rsp_paddr  <= '0;
              rsp_status <= !desc_valid ? XL_SEG_EXC : XL_BOUNDS;
              state      <= S_RESP;
            end else begin
              mem_req_valid <= 1'b1;
              mem_req_addr  <= pte_addr;
              state         <= S_PAGE_RD;
            end
            issued <= 1'b0;
          end
        end
        S_PAGE_RD: begin
          if (rd_done) begin
            rsp_valid  <= 1'b1;
            rsp_paddr  <= desc_valid ? hit_paddr : '0;
            rsp_status <= desc_valid ? XL_OK : XL_PAGE_FLT;
            issued     <= 1'b0;
            state      <= S_RESP;
          end
        end
        default: begin
          if (rsp_ready) begin
            rsp_valid <= 1'b0;
            state     <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/seg_xlate_chk.sv
module seg_xlate_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [ADDR_W-1:0] rsp_paddr,
  input logic [1:0]        rsp_status,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr
);
  logic [1:0] reads;

  always_ff @(posedge clk) begin
    if (rst) reads <= '0;
    else if (req_valid && req_ready) reads <= '0;
    else if (mem_req_valid && mem_req_ready && reads != 2'd3) reads <= reads + 2'd1;
  end

  p_reset_idle_r1: assert property (@(posedge clk)
    $past(rst) |-> (req_ready && !rsp_valid && !mem_req_valid));

  p_seg_exc_one_read_r4: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd1) |-> (reads == 2'd1 && rsp_paddr == '0));

  p_bounds_one_read_r5: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd2) |-> (reads == 2'd1 && rsp_paddr == '0));

  p_page_flt_two_reads_r6: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd3) |-> (reads == 2'd2 && rsp_paddr == '0));

  p_ok_two_reads_r7: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_status == 2'd0) |-> reads == 2'd2);

  p_memreq_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  p_rsp_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) && $stable(rsp_status)));

  p_busy_no_accept_r9: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid || mem_req_valid) |-> !req_ready);
endmodule

bind seg_xlate seg_xlate_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .req_valid     (req_valid),
  .req_ready     (req_ready),
  .rsp_valid     (rsp_valid),
  .rsp_ready     (rsp_ready),
  .rsp_paddr     (rsp_paddr),
  .rsp_status    (rsp_status),
  .mem_req_valid (mem_req_valid),
  .mem_req_ready (mem_req_ready),
  .mem_req_addr  (mem_req_addr)
);

// File: tb/seg_xlate_tb.sv
module seg_xlate_tb;
  localparam int CLK_PERIOD = 10;
  localparam int MAX_CYCLES = 20000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_base = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_vaddr = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [31:0] rsp_paddr;
  logic [1:0]  rsp_status;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data = '0;

  seg_xlate u_dut (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_base(cfg_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr),
    .rsp_status(rsp_status), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int done_cnt = 0;

  logic [31:0] mem [logic [31:0]];
  logic [31:0] exp_pa_q [$];
  logic [1:0]  exp_st_q [$];
  string       exp_tag_q [$];
  logic [31:0] exp_addr_q [$];
  string       addr_tag_q [$];

  function automatic logic [31:0] rd_mem(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] va(input int s, input int p, input int o);
    return {4'(s), 16'(p), 12'(o)};
  endfunction

  function automatic logic [31:0] sdesc(input logic [19:0] b, input int len, input bit v);
    return {b, 11'(len), v};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // capture memory handshakes on the edge, pre-update values
  logic        hs = 1'b0;
  logic [31:0] hs_addr = '0;
  always @(posedge clk) begin
    hs      <= mem_req_valid && mem_req_ready;
    hs_addr <= mem_req_addr;
  end

  // memory model with variable latency and ready stalls
  initial begin
    bit          busy = 0;
    int          cd = 0;
    int          lat = 0;
    int          stall = 0;
    logic [31:0] rd = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (busy) begin
        if (cd == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = rd;
          busy = 0;
        end else cd--;
      end
      if (hs) begin
        if (exp_addr_q.size() == 0) begin
          chk(1'b0, "R4/R5 unexpected table read", hs_addr, 32'h0);
        end else begin
          string t;
          logic [31:0] ea;
          ea = exp_addr_q.pop_front();
          t  = addr_tag_q.pop_front();
          chk(hs_addr == ea, t, hs_addr, ea);
        end
        busy = 1;
        cd   = lat;
        rd   = rd_mem(hs_addr);
        lat  = (lat + 1) % 4;
      end
      mem_req_ready = (stall % 3) != 1;
      stall++;
    end
  end

  // monitor / scoreboard
  initial begin
    int n = 0;
    forever begin
      @(negedge clk);
      if (rst) begin
        rsp_ready = 1'b0;
      end else begin
        rsp_ready = (n % 4) != 2;
        n++;
        if (rsp_valid && req_ready)
          chk(1'b0, "R9 req_ready high while result pending", 32'(req_ready), 32'h0);
        if (rsp_valid && rsp_ready) begin
          if (exp_pa_q.size() == 0) begin
            chk(1'b0, "R9 unexpected result", rsp_paddr, 32'h0);
          end else begin
            logic [31:0] ep;
            logic [1:0]  es;
            string       t;
            ep = exp_pa_q.pop_front();
            es = exp_st_q.pop_front();
            t  = exp_tag_q.pop_front();
            chk(rsp_status == es, {t, " status"}, 32'(rsp_status), 32'(es));
            chk(rsp_paddr == ep, {t, " paddr"}, rsp_paddr, ep);
            done_cnt++;
          end
        end
      end
    end
  end

  task automatic send(input logic [31:0] v, input logic [31:0] a1, input bit two,
                      input logic [31:0] a2, input logic [31:0] pa, input logic [1:0] st,
                      input string tag);
    exp_addr_q.push_back(a1);
    addr_tag_q.push_back({tag, " seg addr"});
    if (two) begin
      exp_addr_q.push_back(a2);
      addr_tag_q.push_back({tag, " page addr"});
    end
    exp_pa_q.push_back(pa);
    exp_st_q.push_back(st);
    exp_tag_q.push_back(tag);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = v;
    @(negedge clk);
    req_valid = 1'b0;
    chk(req_ready == 1'b0, "R9 busy after accept", 32'(req_ready), 32'h0);
  endtask

  task automatic drain();
    while (exp_pa_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    while (cycles < MAX_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    errors++;
    $display("FAIL watchdog actual=%0d expected=<%0d", cycles, MAX_CYCLES);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // segment table at 0x100
    mem[32'h100] = sdesc(20'h00002, 4, 1);
    mem[32'h104] = sdesc(20'h00003, 8, 0);
    mem[32'h108] = sdesc(20'h00004, 0, 1);
    mem[32'h10C] = sdesc(20'h00010, 2047, 1);
    mem[32'h13C] = sdesc(20'h00020, 1, 1);
    mem[32'h2000] = {20'hABCDE, 12'h001};
    mem[32'h2004] = {20'h77777, 12'h000};
    mem[32'h200C] = {20'h12345, 12'h001};
    mem[32'h11FF8] = {20'h55555, 12'h001};
    mem[32'h20000] = {20'hFFFFF, 12'h001};
    // second segment table at 0x800
    mem[32'h800] = sdesc(20'h00030, 1, 1);
    mem[32'h30000] = {20'h0000F, 12'h001};

    repeat (3) @(negedge clk);
    // R1: reset state
    chk(req_ready == 1'b1, "R1 req_ready in reset", 32'(req_ready), 32'h1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid in reset", 32'(rsp_valid), 32'h0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid in reset", 32'(mem_req_valid), 32'h0);
    rst = 1'b0;
    @(negedge clk);
    chk(req_ready == 1'b1 && !rsp_valid && !mem_req_valid, "R1 idle after reset",
        {29'h0, req_ready, rsp_valid, mem_req_valid}, 32'h4);

    cfg_we = 1'b1; cfg_base = 32'h100;
    @(negedge clk);
    cfg_we = 1'b0;

    send(va(0, 0, 'h123), 32'h100, 1, 32'h2000, 32'hABCDE123, 2'd0, "R7 hit page 0");
    send(va(0, 1, 'h040), 32'h100, 1, 32'h2004, 32'h0, 2'd3, "R6 invalid page");
    send(va(0, 3, 'hFFF), 32'h100, 1, 32'h200C, 32'h12345FFF, 2'd0, "R5 last page in range");
    send(va(0, 4, 'h000), 32'h100, 0, 32'h0, 32'h0, 2'd2, "R5 first page past length");
    send(va(1, 0, 'h010), 32'h104, 0, 32'h0, 32'h0, 2'd1, "R4 invalid segment");
    send(va(2, 0, 'h000), 32'h108, 0, 32'h0, 32'h0, 2'd2, "R5 zero length segment");
    send(va(3, 2046, 'h001), 32'h10C, 1, 32'h11FF8, 32'h55555001, 2'd0, "R3 wide page index");
    send(va(3, 2047, 'h001), 32'h10C, 0, 32'h0, 32'h0, 2'd2, "R5 page equals max length");
    send(va(3, 16'hFFFF, 'h001), 32'h10C, 0, 32'h0, 32'h0, 2'd2, "R5 page beyond length field");
    send(va(15, 0, 'hABC), 32'h13C, 1, 32'h20000, 32'hFFFFFABC, 2'd0, "R2 top segment");
    drain();

    cfg_we = 1'b1; cfg_base = 32'h800;
    @(negedge clk);
    cfg_we = 1'b0;
    send(va(0, 0, 'h010), 32'h800, 1, 32'h30000, 32'h0000F010, 2'd0, "R2 new table base");
    send(va(0, 1, 'h010), 32'h800, 0, 32'h0, 32'h0, 2'd2, "R8 bounds under new base");
    drain();

    chk(exp_addr_q.size() == 0, "R8 all table reads issued", 32'(exp_addr_q.size()), 32'h0);
    chk(done_cnt == 12, "R9 result count", 32'(done_cnt), 32'd12);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule